// File: doc/BRIEF.md
# Byte-Lane Controller for Asynchronous Static RAM

This block connects synchronous on-chip logic to an external asynchronous static RAM of up to 64K words of 16 bits. The host raises a request with an address, write data, a per-byte mask and a read/write flag. The controller accepts the request when it is idle. It then runs one complete memory cycle on the active-low strobes and returns a one-cycle acknowledge. A read also returns the 16-bit word, with every byte that the mask leaves out forced to zero.

Every analog limit is a nanosecond parameter, and each one becomes a whole number of clocks by rounding up against the clock-period parameter. With the default 10 ns clock a read holds its strobes for 2 cycles. A write takes four phases of one cycle each:

- a turnaround phase: write enable is low and the bus is released;
- a data phase: the bus is driven;
- a recovery phase: write enable has risen while chip enable and the byte enables stay low;
- the acknowledge.

The write is always ended by write enable. Reads and writes use separate phase counters. The data bus is split into an output, an output enable and an input, so the pad can be placed outside this block.

Top module: `sram_lane_ctl`

## Requirements
- R1: While reset is low, and from the moment it falls even in the middle of a cycle, all memory strobes are high (chip, output, write and both byte enables), the bus output enable and acknowledge are low, and ready is high.
- R2: A request is taken on a clock edge where both req_i and ready_o are high. ready_o stays low from that edge until the acknowledge. A request held high while the controller is busy is taken on the edge after the acknowledge and is not lost.
- R3: A read drives chip enable and output enable low and keeps write enable high for RD = ceil(max(15,7)/10) = 2 cycles. Data is sampled on the last edge of that window. The acknowledge is seen RD+1 cycles after the accepting edge.
- R4: Read data places mask bit 0 on bits 7:0 and mask bit 1 on bits 15:8. A lane whose mask bit is 0 returns 8'h00.
- R5: During a write, output enable stays high. Chip enable, write enable and the selected byte enables fall on the accepting edge.
- R6: The bus output enable rises only after write enable has been low for TA = ceil(7/10) = 1 cycle.
- R7: The bus is driven with the request's write data for DATA = max(ceil(8/10), ceil(10/10)-TA, 1) = 1 cycle, and only while write enable is low. The bus output enable falls on the same edge on which write enable rises.
- R8: The write is ended by write enable. Chip enable and the byte enables stay low for END = max(1, ceil(15/10)-TA-DATA) = 1 cycle after write enable rises, and are then released. The acknowledge is seen TA+DATA+END+1 cycles after the accepting edge.
- R9: The memory address equals the request address and does not change while chip enable is low.
- R10: The byte enable for a lane (bit 0 for the lower byte, bit 1 for the upper byte) is low only if that lane's mask bit is 1. A write with mask 2'b00 leaves the memory unchanged.
- R11: The acknowledge is exactly one cycle long, and ready_o is already high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| ready_o | output | 1 | Idle and able to take a request |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read data with masked lanes zeroed |
| sram_addr_o | output | 16 | Memory address |
| sram_ce_no | output | 1 | Chip enable, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_be_no | output | 2 | Byte enables, active low, bit 0 lower lane |
| sram_dq_o | output | 16 | Data toward the memory |
| sram_dq_oe_o | output | 1 | Drive enable for sram_dq_o |
| sram_dq_i | input | 16 | Data from the memory |

## Verification
A read acknowledge is due on the third falling edge after the accepting edge, and a write acknowledge on the fourth. A memory model returns junk until its read window has elapsed, so a read that samples early gets the wrong data. The model also commits only the bus value it saw while the bus was driven. Stimulus changes and all sampling happen on falling edges. Strobe phases are counted per falling edge from the cycle after acceptance, which makes every phase length an exact count in clocks. The acknowledge and ready are checked on the falling edge where the acknowledge first appears and again on the falling edge after it.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_W_TA,
    ST_W_DATA,
    ST_W_END
  } state_e;

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
  parameter int CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  AST_TMR_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> done_o); // R3

endmodule

// File: rtl/sram_lane_rdcap.sv
module sram_lane_rdcap #(
  parameter int DW     = 16,
  parameter int LANE_W = 8,
  localparam int LANES = DW / LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [LANES-1:0] be_i,
  input  logic [DW-1:0]    dq_i,
  output logic [DW-1:0]    rdata_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    lane_q <= '0;
      else if (cap_i) lane_q <= be_i[l] ? dq_i[l*LANE_W +: LANE_W] : '0;
    end

    assign rdata_o[l*LANE_W +: LANE_W] = lane_q;

    AST_MASKED_LANE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cap_i && !be_i[l]) |=> (rdata_o[l*LANE_W +: LANE_W] == '0)); // R4
  end

endmodule

// File: rtl/sram_lane_ctl.sv
module sram_lane_ctl
  import sram_lane_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int LANE_W  = 8,
  parameter int CLK_NS  = 10,
  parameter int T_AA_NS = 15,  // address to data
  parameter int T_OE_NS = 7,   // output/byte enable to data
  parameter int T_WC_NS = 15,  // write cycle
  parameter int T_SD_NS = 8,   // data setup to write end
  parameter int T_BW_NS = 10,  // byte enable to write end
  parameter int T_WZ_NS = 7,   // write enable low to bus released
  localparam int LANES  = DW / LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [LANES-1:0] be_i,
  output logic             ready_o,
  output logic             ack_o,
  output logic [DW-1:0]    rdata_o,
  output logic [AW-1:0]    sram_addr_o,
  output logic             sram_ce_no,
  output logic             sram_oe_no,
  output logic             sram_we_no,
  output logic [LANES-1:0] sram_be_no,
  output logic [DW-1:0]    sram_dq_o,
  output logic             sram_dq_oe_o,
  input  logic [DW-1:0]    sram_dq_i
);

  localparam int RD_CYC   = ns_to_cyc(max2(T_AA_NS, T_OE_NS), CLK_NS);
  localparam int TA_CYC   = ns_to_cyc(T_WZ_NS, CLK_NS);
  localparam int DATA_CYC = max2(max2(ns_to_cyc(T_SD_NS, CLK_NS),
                                      ns_to_cyc(T_BW_NS, CLK_NS) - TA_CYC), 1);
  localparam int END_CYC  = max2(ns_to_cyc(T_WC_NS, CLK_NS) - TA_CYC - DATA_CYC, 1);
  localparam int MAX_CYC  = max2(max2(RD_CYC, TA_CYC), max2(DATA_CYC, END_CYC));
  localparam int CW       = max2($clog2(MAX_CYC + 1), 1);

  state_e            state_q;
  logic [LANES-1:0]  be_q;
  logic              ce_nq, oe_nq, we_nq, dq_oe_q, ack_q;
  logic [LANES-1:0]  be_nq;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     wdata_q;

  logic              accept;
  logic              rd_load, rd_done, wr_load, wr_done, cap;
  logic [CW-1:0]     wr_load_val;

  assign accept = req_i && (state_q == ST_IDLE);
  assign rd_load = accept && !we_i;
  assign cap     = (state_q == ST_RD) && rd_done;

  always_comb begin
    wr_load     = 1'b0;
    wr_load_val = CW'(TA_CYC - 1);
    unique case (state_q)
      ST_IDLE:   wr_load = accept && we_i;
      ST_W_TA:   begin wr_load = wr_done; wr_load_val = CW'(DATA_CYC - 1); end
      ST_W_DATA: begin wr_load = wr_done; wr_load_val = CW'(END_CYC - 1); end
      default:   wr_load = 1'b0;
    endcase
  end

  sram_lane_timer #(.CW(CW)) i_rd_timer (
    .clk_i, .rst_ni,
    .load_i     (rd_load),
    .load_val_i (CW'(RD_CYC - 1)),
    .done_o     (rd_done)
  );

  sram_lane_timer #(.CW(CW)) i_wr_timer (
    .clk_i, .rst_ni,
    .load_i     (wr_load),
    .load_val_i (wr_load_val),
    .done_o     (wr_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ce_nq   <= 1'b1;
      oe_nq   <= 1'b1;
      we_nq   <= 1'b1;
      be_nq   <= '1;
      dq_oe_q <= 1'b0;
      ack_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else begin
      ack_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          be_q    <= be_i;
          ce_nq   <= 1'b0;
          be_nq   <= ~be_i;
          if (we_i) begin
            we_nq   <= 1'b0;
            state_q <= ST_W_TA;
          end else begin
            oe_nq   <= 1'b0;
            state_q <= ST_RD;
          end
        end
        ST_RD: if (rd_done) begin
          ce_nq   <= 1'b1;
          oe_nq   <= 1'b1;
          be_nq   <= '1;
          ack_q   <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_W_TA: if (wr_done) begin
          dq_oe_q <= 1'b1;
          state_q <= ST_W_DATA;
        end
        ST_W_DATA: if (wr_done) begin
          we_nq   <= 1'b1;   // write ends on write enable
          dq_oe_q <= 1'b0;
          state_q <= ST_W_END;
        end
        ST_W_END: if (wr_done) begin
          ce_nq   <= 1'b1;
          be_nq   <= '1;
          ack_q   <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  sram_lane_rdcap #(.DW(DW), .LANE_W(LANE_W)) i_rdcap (
    .clk_i, .rst_ni,
    .cap_i   (cap),
    .be_i    (be_q),
    .dq_i    (sram_dq_i),
    .rdata_o (rdata_o)
  );

  assign ready_o      = (state_q == ST_IDLE);
  assign ack_o        = ack_q;
  assign sram_addr_o  = addr_q;
  assign sram_ce_no   = ce_nq;
  assign sram_oe_no   = oe_nq;
  assign sram_we_no   = we_nq;
  assign sram_be_no   = be_nq;
  assign sram_dq_o    = wdata_q;
  assign sram_dq_oe_o = dq_oe_q;

  // cycles since write enable fell, for the turnaround check
  logic [CW:0] we_low_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  we_low_cnt_q <= '0;
    else if (sram_we_no)          we_low_cnt_q <= '0;
    else if (we_low_cnt_q != '1)  we_low_cnt_q <= we_low_cnt_q + 1'b1;
  end

  AST_TURNAROUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_dq_oe_o) |-> (we_low_cnt_q >= (CW+1)'(TA_CYC))); // R6
  AST_DQ_NEEDS_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> (!sram_we_no && sram_oe_no)); // R7
  AST_DQ_OFF_AT_WE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> !sram_dq_oe_o); // R7
  AST_NO_OE_WITH_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sram_oe_no && !sram_we_no)); // R5
  AST_WE_UNDER_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> !sram_ce_no); // R8
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_no && $past(!sram_ce_no)) |-> $stable(sram_addr_o)); // R9
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R11
  AST_READY_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ready_o); // R11
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_ce_no |-> !ready_o); // R2

endmodule

// File: tb/test_sram_lane_ctl.sv
module test_sram_lane_ctl;

  function automatic int cdiv(input int ns);
    int c;
    c = (ns + 9) / 10;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_EXP   = cdiv(15);
  localparam int TA_EXP   = cdiv(7);
  localparam int DATA_EXP = mx(mx(cdiv(8), cdiv(10) - TA_EXP), 1);
  localparam int END_EXP  = mx(cdiv(15) - TA_EXP - DATA_EXP, 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req = 1'b0, wr = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic [1:0]  be_in = '0;
  logic        ready, ack;
  logic [15:0] rdata, m_addr, dq_o, dq_i;
  logic        ce_n, oe_n, we_n, dq_oe;
  logic [1:0]  be_n;

  sram_lane_ctl i_sram_lane_ctl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(wr), .addr_i(addr),
    .wdata_i(wdata), .be_i(be_in), .ready_o(ready), .ack_o(ack), .rdata_o(rdata),
    .sram_addr_o(m_addr), .sram_ce_no(ce_n), .sram_oe_no(oe_n), .sram_we_no(we_n),
    .sram_be_no(be_n), .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i)
  );

  // memory model, 256 words indexed by addr[7:0]
  logic [15:0] mem [256] = '{default: 16'h0000};
  logic [15:0] wr_bus = 16'hBAD0;
  int          rd_age = 0;

  always @(negedge clk) wr_bus <= dq_oe ? dq_o : 16'hBAD0;

  always @(posedge we_n)
    if (ce_n === 1'b0)
      for (int l = 0; l < 2; l++)
        if (be_n[l] === 1'b0) mem[m_addr[7:0]][l*8 +: 8] <= wr_bus[l*8 +: 8];

  always @(posedge clk)
    rd_age <= (!ce_n && !oe_n && we_n) ? rd_age + 1 : 0;

  always_comb begin
    for (int l = 0; l < 2; l++) begin
      if (!ce_n && !oe_n && we_n && !be_n[l])
        dq_i[l*8 +: 8] = (rd_age + 1 >= RD_EXP) ? mem[m_addr[7:0]][l*8 +: 8] : 8'h5A;
      else
        dq_i[l*8 +: 8] = 8'hEE;
    end
  end

  // phase monitor: cumulative counters, sampled at falling edges
  logic [15:0] exp_addr = '0, exp_wd = '0;
  logic [1:0]  exp_be_n = 2'b11;
  int ta_obs = 0, data_obs = 0, end_obs = 0, oe_obs = 0, we_obs = 0;
  int lane_bad = 0, addr_bad = 0, dq_bad = 0;
  logic we_seen = 1'b0;

  always @(negedge clk) begin
    if (!ce_n) begin
      if (be_n !== exp_be_n) lane_bad <= lane_bad + 1;
      if (m_addr !== exp_addr) addr_bad <= addr_bad + 1;
      if (!oe_n) oe_obs <= oe_obs + 1;
      if (!we_n) we_obs <= we_obs + 1;
      if (!we_n && !dq_oe) ta_obs <= ta_obs + 1;
      if (we_n && we_seen) end_obs <= end_obs + 1;
    end
    if (dq_oe) begin
      data_obs <= data_obs + 1;
      if (we_n || dq_o !== exp_wd) dq_bad <= dq_bad + 1;
    end
    we_seen <= ce_n ? 1'b0 : (we_seen || !we_n);
  end

  int n_chk = 0, n_err = 0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic run_txn(input logic w, input logic [1:0] b, input logic [15:0] a,
                         input logic [15:0] wd, input logic [15:0] exp_rd);
    int cyc, busy;
    int s_ta, s_data, s_end, s_oe, s_we, s_lane, s_addr, s_dq;
    @(negedge clk);
    exp_addr = a; exp_wd = wd; exp_be_n = ~b;
    s_ta = ta_obs; s_data = data_obs; s_end = end_obs; s_oe = oe_obs; s_we = we_obs;
    s_lane = lane_bad; s_addr = addr_bad; s_dq = dq_bad;
    req = 1'b1; wr = w; be_in = b; addr = a; wdata = wd;
    while (!ready) @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    cyc = 1; busy = 0;
    while (!ack && cyc < 50) begin
      if (!ready) busy++;
      @(negedge clk);
      cyc++;
    end
    chk("R11 ready during ack", 32'(ready), 32'd1);
    chk("R2 busy cycles", busy, w ? TA_EXP + DATA_EXP + END_EXP : RD_EXP);
    chk("R10 lanes", lane_bad - s_lane, 0);
    chk("R9 address", addr_bad - s_addr, 0);
    if (w) begin
      chk("R8 write latency", cyc, TA_EXP + DATA_EXP + END_EXP + 1);
      chk("R6 turnaround", ta_obs - s_ta, TA_EXP);
      chk("R7 data phase", data_obs - s_data, DATA_EXP);
      chk("R7 data value", dq_bad - s_dq, 0);
      chk("R8 recovery", end_obs - s_end, END_EXP);
      chk("R5 oe high", oe_obs - s_oe, 0);
    end else begin
      chk("R3 read latency", cyc, RD_EXP + 1);
      chk("R3 oe window", oe_obs - s_oe, RD_EXP);
      chk("R3 we high", we_obs - s_we, 0);
      chk("R4 rdata", rdata, exp_rd);
    end
    @(negedge clk);
    chk("R11 ack one cycle", 32'(ack), 32'd0);
  endtask

  // {we, be[1:0], addr, wdata, expected read}
  localparam logic [50:0] VEC [14] = '{
    {1'b1, 2'b11, 16'h0010, 16'h1234, 16'h0000},
    {1'b1, 2'b11, 16'h0021, 16'hABCD, 16'h0000},
    {1'b0, 2'b11, 16'h0010, 16'h0000, 16'h1234},
    {1'b1, 2'b01, 16'h0010, 16'hFF56, 16'h0000},
    {1'b0, 2'b11, 16'h0010, 16'h0000, 16'h1256},
    {1'b1, 2'b10, 16'h0021, 16'h77EE, 16'h0000},
    {1'b0, 2'b11, 16'h0021, 16'h0000, 16'h77CD},
    {1'b0, 2'b01, 16'h0021, 16'h0000, 16'h00CD},
    {1'b0, 2'b10, 16'h0010, 16'h0000, 16'h1200},
    {1'b1, 2'b00, 16'h0010, 16'hFFFF, 16'h0000},
    {1'b0, 2'b11, 16'h0010, 16'h0000, 16'h1256},
    {1'b0, 2'b00, 16'h0021, 16'h0000, 16'h0000},
    {1'b1, 2'b11, 16'hFF33, 16'h0F0F, 16'h0000},
    {1'b0, 2'b11, 16'hFF33, 16'h0000, 16'h0F0F}
  };

  int wd_cyc = 0;
  always @(posedge clk) begin
    wd_cyc <= wd_cyc + 1;
    if (wd_cyc > 20000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", wd_cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int cyc;
    #9;
    chk("R1 reset strobes", {27'd0, ce_n, oe_n, we_n, be_n}, {27'd0, 5'b11111});
    chk("R1 reset dq_oe/ack", {30'd0, dq_oe, ack}, 32'd0);
    chk("R1 reset ready", 32'(ready), 32'd1);
    @(negedge clk); rst_n = 1'b1;

    foreach (VEC[i])
      run_txn(VEC[i][50], VEC[i][49:48], VEC[i][47:32], VEC[i][31:16], VEC[i][15:0]);

    // R2: second request held high while busy is taken after the ack
    @(negedge clk);
    exp_addr = 16'h0044; exp_be_n = 2'b00; exp_wd = 16'hBEEF;
    req = 1'b1; wr = 1'b1; be_in = 2'b11; addr = 16'h0044; wdata = 16'hBEEF;
    @(negedge clk);
    wr = 1'b0;
    chk("R2 ready low while busy", 32'(ready), 32'd0);
    while (!ack) @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    chk("R2 held request taken", 32'(ready), 32'd0);
    cyc = 1;
    while (!ack && cyc < 50) begin @(negedge clk); cyc++; end
    chk("R2 held read latency", cyc, RD_EXP + 1);
    chk("R2 held read data", rdata, 16'hBEEF);

    // R1: reset in the middle of a write releases every strobe at once
    @(negedge clk);
    req = 1'b1; wr = 1'b1; be_in = 2'b11; addr = 16'h0050; wdata = 16'h1111;
    @(negedge clk);
    req = 1'b0;
    chk("R1 write started", 32'(we_n), 32'd0);
    rst_n = 1'b0;
    #1;
    chk("R1 mid-cycle reset strobes", {27'd0, ce_n, oe_n, we_n, be_n}, {27'd0, 5'b11111});
    chk("R1 mid-cycle reset dq_oe", 32'(dq_oe), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    run_txn(1'b0, 2'b11, 16'h0021, 16'h0000, 16'h77CD);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule